// File: doc/BRIEF.md
# Banked OUT Pipe Buffer Controller

This block holds the outgoing data of one host OUT pipe in one or two equally sized byte banks. Software and a transmit engine pass these banks back and forth. Software pushes bytes into its current bank through a byte port. It then acknowledges a per-bank "bank free" flag with a clear strobe and hands the bank over with a release strobe. The transmit engine takes released banks in the order they were released and streams their bytes out with a valid/ready handshake. When an acknowledge arrives for a bank, the engine gives that bank back to software empty, with its "bank free" flag raised again.

Software sees three status lines: the free flag and the ownership bit of its current bank, and a write-allowed flag. With two banks, a release moves software to the other bank, and the status lines then describe that bank. Software can therefore fill one bank while the other is on the wire. A suspend request is honoured only while no bank is waiting or in flight. Any bank that is pending is sent first, and the request takes effect afterwards.

Top module: `out_pipe_bank_ctrl`

## Requirements
- R1: After reset every bank is empty and owned by software. `irq_free`, `own_sw` and `wr_allowed` are 1, and `tx_valid` and `susp_active` are 0.
- R2: An accepted byte is stored at the next free position of the current bank. A released bank holding N bytes is emitted on `tx_data` in write order, one byte per cycle where `tx_ready` is high, with `tx_last` high on byte N. A bank with N=0 emits no bytes.
- R3: A pulse on `sw_irq_clr` clears the free flag of the current bank. It changes neither the bank's contents nor `own_sw` nor `wr_allowed`.
- R4: A pulse on `sw_own_clr` while `irq_free` is 1 is ignored: the current bank stays with software and nothing is transmitted.
- R5: A pulse on `sw_own_clr` while `irq_free` is 0 and `own_sw` is 1 hands the current bank to the transmit engine. With two banks, the current bank switches to the other one and the flags show that bank. With one bank, `own_sw` and `wr_allowed` become 0 until the bank is returned.
- R6: `wr_allowed` is 1 exactly when the current bank is owned by software and holds fewer than BANK_BYTES bytes.
- R7: A write while `wr_allowed` is 0 is dropped. `wr_err` is high in the cycle after that write.
- R8: `susp_active` equals `suspend_req` only while no bank is released, in transmission or awaiting acknowledge. Otherwise it is 0, and pending banks are still transmitted.
- R9: Banks are transmitted strictly in release order. An `ack` pulse while the engine waits for it returns the bank to software empty, with its free flag set.
- R10: With two banks, the second bank can be filled and released while the first is in transmission. Its first byte appears on `tx_valid` within two cycles after the `ack` of the first bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_valid | input | 1 | Software byte write strobe |
| sw_wr_data | input | 8 | Byte to write |
| sw_irq_clr | input | 1 | Clears the free flag of the current bank |
| sw_own_clr | input | 1 | Releases the current bank to the transmit engine |
| suspend_req | input | 1 | Requested suspend level |
| tx_ready | input | 1 | Downstream accepts a byte |
| ack | input | 1 | Handshake acknowledge for the bank awaiting it |
| irq_free | output | 1 | Free flag of the current bank |
| own_sw | output | 1 | 1 when software owns the current bank |
| wr_allowed | output | 1 | Current bank can take another byte |
| wr_err | output | 1 | One-cycle pulse after a dropped write |
| tx_valid | output | 1 | A byte is offered on tx_data |
| tx_data | output | 8 | Transmitted byte |
| tx_last | output | 1 | Offered byte is the last of its bank |
| susp_active | output | 1 | Suspend currently in effect |

## Verification
The main function is tried over every fill level from empty to full, in both banks and over two rounds, each with a distinct byte pattern. These runs separate correct write ordering, the end-of-bank marker and the zero-length case. An overlapped run fills and releases the second bank while the first is still unacknowledged. It tells strict release order and back-to-back start apart from a design that starts early or stalls. Strobes issued while the flag is set or the bank is full, a suspend request against a pending bank, and a one-bank instance cover the refusal paths.

// File: rtl/opb_pkg.sv
package opb_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_WAIT
    } tx_state_e;

    typedef struct packed {
        logic hw_owned;
        logic irq_pend;
    } bank_flags_t;

    function automatic logic step_bank(input logic cur, input int nb);
        return (nb > 1) ? ~cur : 1'b0;
    endfunction

endpackage

// File: rtl/opb_bank_mem.sv
module opb_bank_mem
    import opb_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 8,
    localparam int IDX_W  = $clog2(BANK_BYTES),
    localparam int DEPTH  = NUM_BANKS * BANK_BYTES,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  byte_t            wr_data,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output byte_t            rd_data
);

    byte_t store [DEPTH];

    function automatic logic [ADDR_W-1:0] flat(input logic b, input logic [IDX_W-1:0] i);
        return ADDR_W'(int'(b) * BANK_BYTES + int'(i));
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) store[flat(wr_bank, wr_idx)] <= wr_data;
    end

    assign rd_data = store[flat(rd_bank, rd_idx)];

endmodule

// File: rtl/opb_tx_engine.sv
module opb_tx_engine
    import opb_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 8,
    localparam int IDX_W = $clog2(BANK_BYTES),
    localparam int CNT_W = $clog2(BANK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             head_hw,
    input  logic [CNT_W-1:0] head_cnt,
    input  logic             tx_ready,
    input  logic             ack_in,
    output logic             head_bank,
    output logic [IDX_W-1:0] rd_idx,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             ret_pulse,
    output logic             busy
);

    tx_state_e state;

    assign tx_valid  = (state == TX_SEND);
    assign tx_last   = tx_valid && ((CNT_W'(rd_idx) + CNT_W'(1)) == head_cnt);
    assign ret_pulse = (state == TX_WAIT) && ack_in;
    assign busy      = (state != TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            head_bank <= 1'b0;
            rd_idx    <= '0;
        end else begin
            unique case (state)
                TX_IDLE: if (head_hw) begin
                    rd_idx <= '0;
                    state  <= (head_cnt == '0) ? TX_WAIT : TX_SEND;
                end
                TX_SEND: if (tx_ready) begin
                    if (tx_last) state  <= TX_WAIT;
                    else         rd_idx <= rd_idx + 1'b1;
                end
                TX_WAIT: if (ack_in) begin
                    state     <= TX_IDLE;
                    head_bank <= step_bank(head_bank, NUM_BANKS);
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R9: the engine only works on a bank that software has released
    a_r9_engine_owns: assert property (@(posedge clk) disable iff (rst)
        busy |-> head_hw);

endmodule

// File: rtl/out_pipe_bank_ctrl.sv
module out_pipe_bank_ctrl
    import opb_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 8,
    localparam int IDX_W = $clog2(BANK_BYTES),
    localparam int CNT_W = $clog2(BANK_BYTES + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_wr_valid,
    input  logic [7:0] sw_wr_data,
    input  logic       sw_irq_clr,
    input  logic       sw_own_clr,
    input  logic       suspend_req,
    input  logic       tx_ready,
    input  logic       ack,
    output logic       irq_free,
    output logic       own_sw,
    output logic       wr_allowed,
    output logic       wr_err,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last,
    output logic       susp_active
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BANK_BYTES);

    bank_flags_t      fl  [2];
    logic [CNT_W-1:0] cnt [2];
    logic             cur;

    logic             head_bank, ret_pulse, eng_busy;
    logic [IDX_W-1:0] rd_idx;
    logic             wr_ok, rel_ok;
    bank_flags_t      cur_fl;

    assign cur_fl = fl[cur];
    assign wr_ok  = sw_wr_valid && !cur_fl.hw_owned && (cnt[cur] != FULL);
    assign rel_ok = sw_own_clr && !cur_fl.hw_owned && !cur_fl.irq_pend;

    assign irq_free    = cur_fl.irq_pend;
    assign own_sw      = !cur_fl.hw_owned;
    assign wr_allowed  = !cur_fl.hw_owned && (cnt[cur] != FULL);
    assign susp_active = suspend_req && !eng_busy && !fl[0].hw_owned && !fl[1].hw_owned;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= 1'b0;
            wr_err <= 1'b0;
            for (int b = 0; b < 2; b++) begin
                fl[b]  <= '{hw_owned: 1'b0, irq_pend: 1'b1};
                cnt[b] <= '0;
            end
        end else begin
            wr_err <= sw_wr_valid && !wr_ok;
            for (int b = 0; b < 2; b++) begin
                if (ret_pulse && (head_bank == 1'(b))) begin
                    fl[b]  <= '{hw_owned: 1'b0, irq_pend: 1'b1};
                    cnt[b] <= '0;
                end else if (cur == 1'(b)) begin
                    if (wr_ok)      cnt[b]         <= cnt[b] + 1'b1;
                    if (sw_irq_clr) fl[b].irq_pend <= 1'b0;
                    if (rel_ok)     fl[b].hw_owned <= 1'b1;
                end
            end
            if (rel_ok) cur <= step_bank(cur, NUM_BANKS);
        end
    end

    opb_bank_mem #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) u_mem (
        .clk     (clk),
        .wr_en   (wr_ok),
        .wr_bank (cur),
        .wr_idx  (cnt[cur][IDX_W-1:0]),
        .wr_data (sw_wr_data),
        .rd_bank (head_bank),
        .rd_idx  (rd_idx),
        .rd_data (tx_data)
    );

    opb_tx_engine #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .head_hw   (fl[head_bank].hw_owned),
        .head_cnt  (cnt[head_bank]),
        .tx_ready  (tx_ready),
        .ack_in    (ack),
        .head_bank (head_bank),
        .rd_idx    (rd_idx),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .ret_pulse (ret_pulse),
        .busy      (eng_busy)
    );

    // R4: a release while the free flag is still set leaves the current bank in place
    a_r4_release_refused: assert property (@(posedge clk) disable iff (rst)
        (sw_own_clr && irq_free) |=> $stable(cur));

    // R5: an accepted release puts the bank under hardware ownership
    a_r5_release_taken: assert property (@(posedge clk) disable iff (rst)
        (sw_own_clr && own_sw && !irq_free) |=> fl[$past(cur)].hw_owned);

    // R6: a bank never holds more than its capacity
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        (cnt[0] <= FULL) && (cnt[1] <= FULL));

    // R7: a write that is not allowed raises the error pulse
    a_r7_drop_flagged: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_valid && !wr_allowed) |=> wr_err);

    // R8: suspend never takes effect while a bank is pending
    a_r8_suspend_refused: assert property (@(posedge clk) disable iff (rst)
        (fl[0].hw_owned || fl[1].hw_owned) |-> !susp_active);

endmodule

// File: tb/out_pipe_bank_ctrl_tb.sv
module out_pipe_bank_ctrl_tb;

    localparam int BB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       wv = 0, ic = 0, oc = 0, sr = 0, ak = 0, tr = 1;
    logic [7:0] wd = 0;
    logic       irq, own, wal, werr, txv, txl, susp;
    logic [7:0] txd;

    logic       o_wv = 0, o_ic = 0, o_oc = 0, o_ak = 0;
    logic [7:0] o_wd = 0;
    logic       o_irq, o_own, o_wal, o_werr, o_txv, o_txl, o_susp;
    logic [7:0] o_txd;

    int errors = 0;
    int checks = 0;
    logic [7:0] got [$];
    logic       gotl [$];
    int         o_bytes = 0;

    out_pipe_bank_ctrl #(.NUM_BANKS(2), .BANK_BYTES(BB)) u_dut (
        .clk(clk), .rst(rst), .sw_wr_valid(wv), .sw_wr_data(wd), .sw_irq_clr(ic),
        .sw_own_clr(oc), .suspend_req(sr), .tx_ready(tr), .ack(ak),
        .irq_free(irq), .own_sw(own), .wr_allowed(wal), .wr_err(werr),
        .tx_valid(txv), .tx_data(txd), .tx_last(txl), .susp_active(susp));

    out_pipe_bank_ctrl #(.NUM_BANKS(1), .BANK_BYTES(BB)) u_one (
        .clk(clk), .rst(rst), .sw_wr_valid(o_wv), .sw_wr_data(o_wd), .sw_irq_clr(o_ic),
        .sw_own_clr(o_oc), .suspend_req(1'b0), .tx_ready(1'b1), .ack(o_ak),
        .irq_free(o_irq), .own_sw(o_own), .wr_allowed(o_wal), .wr_err(o_werr),
        .tx_valid(o_txv), .tx_data(o_txd), .tx_last(o_txl), .susp_active(o_susp));

    always @(negedge clk) begin
        if (!rst && txv && tr) begin
            got.push_back(txd);
            gotl.push_back(txl);
        end
        if (!rst && o_txv) o_bytes++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wv = 1; wd = d;
        @(negedge clk); wv = 0;
    endtask
    task automatic clr_irq();
        @(negedge clk); ic = 1;
        @(negedge clk); ic = 0;
    endtask
    task automatic rel();
        @(negedge clk); oc = 1;
        @(negedge clk); oc = 0;
    endtask
    task automatic do_ack();
        @(negedge clk); ak = 1;
        @(negedge clk); ak = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wait_bytes(input int n);
        for (int k = 0; k < 40 && got.size() < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk("R1 irq_free", irq, 1);
        chk("R1 own_sw", own, 1);
        chk("R1 wr_allowed", wal, 1);
        chk("R1 tx_valid", txv, 0);
        chk("R1 susp_active", susp, 0);
        chk("R1 one-bank irq_free", o_irq, 1);
        chk("R1 one-bank wr_allowed", o_wal, 1);

        // Sweep fill levels 0..BB over two rounds; banks alternate each release
        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int len = 0; len <= BB; len++) begin
                got.delete(); gotl.delete();
                for (int i = 0; i < len; i++) wr(8'(rnd * 64 + len * 8 + i + 1));
                chk("R6 wr_allowed after fill", wal, (len < BB) ? 1 : 0);
                if (len == BB) begin
                    wr(8'hEE);
                    chk("R7 wr_err on full bank", werr, 1);
                end
                chk("R9 returned bank has free flag", irq, 1);
                rel();
                idle(3);
                chk("R4 own_sw after refused release", own, 1);
                chk("R4 nothing sent", got.size(), 0);
                clr_irq();
                chk("R3 irq_free cleared", irq, 0);
                chk("R3 own_sw unchanged", own, 1);
                chk("R3 wr_allowed unchanged", wal, (len < BB) ? 1 : 0);
                rel();
                chk("R5 next bank irq_free", irq, 1);
                chk("R5 next bank own_sw", own, 1);
                chk("R5 next bank wr_allowed", wal, 1);
                wait_bytes(len);
                idle(3);
                chk("R2 byte count", got.size(), len);
                for (int i = 0; i < len && i < got.size(); i++) begin
                    chk("R2 byte value", got[i], 8'(rnd * 64 + len * 8 + i + 1));
                    chk("R2 last marker", gotl[i], (i == len - 1) ? 1 : 0);
                end
                do_ack();
                idle(2);
            end
        end

        // Overlap: 10 releases done, current is bank 0
        got.delete(); gotl.delete();
        for (int i = 0; i < 3; i++) wr(8'(8'hA0 + i));
        clr_irq(); rel();
        chk("R10 other bank writable during transfer", wal, 1);
        for (int i = 0; i < 2; i++) wr(8'(8'hB0 + i));
        clr_irq(); rel();
        chk("R6 own_sw with both banks out", own, 0);
        chk("R6 wr_allowed with both banks out", wal, 0);
        wr(8'h55);
        chk("R7 wr_err on hardware-owned bank", werr, 1);
        wait_bytes(3);
        idle(3);
        chk("R9 second bank waits for ack", got.size(), 3);
        do_ack();
        begin
            int waited = 0;
            while (!txv && waited < 5) begin @(negedge clk); waited++; end
            chk("R10 start delay after ack", (waited <= 2) ? 1 : 0, 1);
        end
        wait_bytes(5);
        idle(2);
        chk("R9 total bytes", got.size(), 5);
        for (int i = 0; i < 5 && i < got.size(); i++)
            chk("R9 release order", got[i], (i < 3) ? 8'hA0 + i : 8'hB0 + i - 3);
        chk("R9 returned bank irq_free", irq, 1);
        chk("R9 returned bank own_sw", own, 1);
        chk("R9 returned bank wr_allowed", wal, 1);
        do_ack();
        idle(2);

        // Suspend against a pending bank; current is bank 0
        sr = 1;
        idle(1);
        chk("R8 suspend taken when idle", susp, 1);
        got.delete(); gotl.delete();
        wr(8'h77); clr_irq(); rel();
        chk("R8 suspend refused while pending", susp, 0);
        wait_bytes(1);
        idle(2);
        chk("R8 pending bank sent", got.size(), 1);
        chk("R8 still refused before ack", susp, 0);
        do_ack();
        idle(2);
        chk("R8 suspend resumes after return", susp, 1);
        sr = 0;
        idle(1);
        chk("R8 suspend follows request", susp, 0);

        // One-bank instance
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); o_wv = 1; o_wd = 8'(i + 3);
            @(negedge clk); o_wv = 0;
        end
        @(negedge clk); o_ic = 1;
        @(negedge clk); o_ic = 0; o_oc = 1;
        @(negedge clk); o_oc = 0;
        chk("R5 one-bank own_sw after release", o_own, 0);
        chk("R5 one-bank wr_allowed after release", o_wal, 0);
        chk("R5 one-bank irq_free after release", o_irq, 0);
        @(negedge clk); o_wv = 1;
        @(negedge clk); o_wv = 0;
        chk("R7 one-bank wr_err", o_werr, 1);
        idle(5);
        chk("R2 one-bank bytes sent", o_bytes, 2);
        @(negedge clk); o_ak = 1;
        @(negedge clk); o_ak = 0;
        chk("R9 one-bank irq_free on return", o_irq, 1);
        chk("R9 one-bank own_sw on return", o_own, 1);
        chk("R9 one-bank wr_allowed on return", o_wal, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule